// File: doc/BRIEF.md
# Link State Transition Trace Buffer

This block keeps a short history of a link training state machine's movements. On every clock it samples the current link state, which is made of a 4-bit major state and two 3-bit minor states, one for the transmit side and one for the receive side. A new entry goes into a 32-entry trace memory only when that triple differs from the entry recorded last. The two minor states are kept apart, so one entry can show a transmitter that has moved on while the receiver has not.

Software reaches the buffer through two 32-bit registers. The control register turns recording on, clears the buffer, and can hold recording back until a programmed state is seen. The status register always shows the write pointer and a full flag. Software writes an entry index into that register and then reads it back to get the selected entry. While the full flag is clear, only the entries below the write pointer are meaningful. Once it is set, all 32 are.

Major state codes: detect 0, polling 1, configuration 2, L0 4, L1 5, L2 6, recovery 7, loopback 8, hot reset 9, disabled 10, transmitter-character 11. Code 3 is not used. Any 4-bit value is stored as given.

Top module: `link_trace_buf`

## Requirements
- R1: After reset both read words are zero. This covers write pointer, full flag, read index and the control fields.
- R2: An entry is written only on a clock where the sampled triple {major, tx minor, rx minor} differs from the triple recorded last, or where nothing has been recorded since the last clear. Each entry written advances the write pointer (status bits [5:1]) by exactly one.
- R3: Reading back an entry returns the major state in status bits [15:12], the transmit minor in bits [18:16] and the receive minor in bits [21:19].
- R4: A status-register write loads the read index from data bits [10:6]. Status bit 11 is set when the full flag is set or when the index is below the write pointer. When bit 11 is clear, bits [21:12] read zero.
- R5: When an entry is written at index 31, the pointer wraps to 0 and the full flag (status bit 0) sets. The flag stays set until a clear. Later entries overwrite the oldest ones.
- R6: While control bit 2 is high, nothing is recorded and the pointer, full flag and trigger-armed state are held at zero. The first state sampled after the bit is released is recorded even if it equals the last entry written before the clear.
- R7: With control bit 0 low, nothing is recorded.
- R8: With control bit 3 high, recording stays off until the sampled triple equals the trigger fields: major in control [7:4], tx minor in [10:8], rx minor in [13:11]. That matching state is recorded, and recording then continues normally until the next clear.
- R9: The transmit and receive minor states are stored independently of each other within one entry.
- R10: The control register reads back written bits [13:0] with bit 1 forced to zero. Bits [31:14] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ls_major | input | 4 | Sampled major link state |
| ls_tx_minor | input | 3 | Sampled transmit-side minor state |
| ls_rx_minor | input | 3 | Sampled receive-side minor state |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control register read word |
| stat_rdata | output | 32 | Status register read word, including the selected entry |

## Verification
The hardest situation to reach from the ports is a full buffer whose oldest entries have been overwritten. Only at that point do the full flag, the wrapped pointer and the overwritten slot 0 all show at once. The stimulus clears the buffer and then drives forty consecutive distinct states, so that slot 0 holds the thirty-third state. It then reads that slot back through the index window. The trigger wait is the second hard case. The stimulus drives states that match the trigger in two of the three fields but not all three, then the exact match, then a repeat of it. A behavioural model is compared against both read words on every clock.

// File: rtl/ltb_pkg.sv
package ltb_pkg;
  typedef enum logic [3:0] {
    LS_DETECT   = 4'd0,
    LS_POLLING  = 4'd1,
    LS_CONFIG   = 4'd2,
    LS_L0       = 4'd4,
    LS_L1       = 4'd5,
    LS_L2       = 4'd6,
    LS_RECOVERY = 4'd7,
    LS_LOOPBACK = 4'd8,
    LS_HOTRESET = 4'd9,
    LS_DISABLED = 4'd10,
    LS_TXCHAR   = 4'd11
  } link_major_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_CLR_BIT  = 2;
  localparam int CTL_TRIG_BIT = 3;
  localparam int CTL_TFLD_LSB = 4;
endpackage

// File: rtl/ltb_capture.sv
module ltb_capture #(
  parameter int DEPTH = 32,
  parameter int MAJ_W = 4,
  parameter int MIN_W = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ENT_W = MAJ_W + 2*MIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             clear,
  input  logic             trig_en,
  input  logic [ENT_W-1:0] trig_val,
  input  logic [ENT_W-1:0] cur_val,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic [ENT_W-1:0] wdata,
  output logic [PTR_W-1:0] wptr,
  output logic             full
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH-1);

  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic             full_q, full_d;
  logic [ENT_W-1:0] last_q, last_d;
  logic             have_q, have_d;
  logic             armed_q, armed_d;
  logic             match, go, fresh;

  always_comb begin
    match = (cur_val == trig_val);
    go    = !trig_en || armed_q || match;
    fresh = !have_q || (cur_val != last_q);
    we    = cap_en && !clear && go && fresh;
  end

  always_comb begin
    wptr_d  = wptr_q;
    full_d  = full_q;
    last_d  = last_q;
    have_d  = have_q;
    armed_d = armed_q;
    if (clear) begin
      wptr_d  = '0;
      full_d  = 1'b0;
      have_d  = 1'b0;
      armed_d = 1'b0;
    end else begin
      if (cap_en && trig_en && match) armed_d = 1'b1;
      if (we) begin
        wptr_d = (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
        if (wptr_q == LAST_IDX) full_d = 1'b1;
        last_d = cur_val;
        have_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      full_q  <= 1'b0;
      last_q  <= '0;
      have_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      full_q  <= full_d;
      last_q  <= last_d;
      have_q  <= have_d;
      armed_q <= armed_d;
    end
  end

  assign waddr = wptr_q;
  assign wdata = cur_val;
  assign wptr  = wptr_q;
  assign full  = full_q;

  AST_PTR_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_q != $past(wptr_q)) |-> ($past(clear) || wptr_q == $past(wptr_q) + 1'b1)); // R2
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clear) |=> full_q); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (wptr_q == '0 && !full_q && !armed_q)); // R6
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !clear) |=> ($stable(wptr_q) && $stable(full_q))); // R7
  AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en && !armed_q && cur_val != trig_val) |-> !we); // R8
endmodule

// File: rtl/ltb_ram.sv
module ltb_ram #(
  parameter int DEPTH = 32,
  parameter int ENT_W = 10,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic             cell_en;
    logic [ENT_W-1:0] cell_q;
    assign cell_en = we && (waddr == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= '0;
      else if (cell_en) cell_q <= wdata;
    end
    assign cells[i] = cell_q;
  end

  assign rdata = cells[raddr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cells[$past(waddr)] == $past(wdata))); // R3
endmodule

// File: rtl/ltb_regs.sv
module ltb_regs
  import ltb_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int DEPTH = 32,
  parameter int MAJ_W = 4,
  parameter int MIN_W = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int ENT_W = MAJ_W + 2*MIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wdata,
  input  logic [PTR_W-1:0] wptr,
  input  logic             full,
  input  logic [ENT_W-1:0] entry,
  output logic             cap_en,
  output logic             clear,
  output logic             trig_en,
  output logic [ENT_W-1:0] trig_val,
  output logic [PTR_W-1:0] rd_idx,
  output logic [REG_W-1:0] ctrl_rd,
  output logic [REG_W-1:0] stat_rd
);
  localparam int CTL_W   = CTL_TFLD_LSB + ENT_W;
  localparam int T_TX    = CTL_TFLD_LSB + MAJ_W;
  localparam int T_RX    = T_TX + MIN_W;
  localparam int PTR_LSB = 1;
  localparam int IDX_LSB = PTR_LSB + PTR_W;
  localparam int VLD_BIT = IDX_LSB + PTR_W;
  localparam int MAJ_LSB = VLD_BIT + 1;
  localparam int TX_LSB  = MAJ_LSB + MAJ_W;
  localparam int RX_LSB  = TX_LSB + MIN_W;
  localparam logic [CTL_W-1:0] CTL_MASK = ~(CTL_W'(1) << 1);

  logic [CTL_W-1:0] ctrl_q, ctrl_d;
  logic [PTR_W-1:0] idx_q, idx_d;
  logic             valid;

  always_comb begin
    ctrl_d = ctrl_q;
    idx_d  = idx_q;
    if (wr_en && !wr_sel) ctrl_d = wdata[CTL_W-1:0] & CTL_MASK;
    if (wr_en && wr_sel)  idx_d  = wdata[IDX_LSB +: PTR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      idx_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      idx_q  <= idx_d;
    end
  end

  assign cap_en   = ctrl_q[CTL_EN_BIT];
  assign clear    = ctrl_q[CTL_CLR_BIT];
  assign trig_en  = ctrl_q[CTL_TRIG_BIT];
  assign trig_val = {ctrl_q[CTL_TFLD_LSB +: MAJ_W], ctrl_q[T_TX +: MIN_W], ctrl_q[T_RX +: MIN_W]};
  assign rd_idx   = idx_q;
  assign ctrl_rd  = REG_W'(ctrl_q);

  always_comb begin
    valid = full || (idx_q < wptr);
    stat_rd = '0;
    stat_rd[0] = full;
    stat_rd[PTR_LSB +: PTR_W] = wptr;
    stat_rd[IDX_LSB +: PTR_W] = idx_q;
    stat_rd[VLD_BIT] = valid;
    if (valid) begin
      stat_rd[MAJ_LSB +: MAJ_W] = entry[ENT_W-1 -: MAJ_W];
      stat_rd[TX_LSB +: MIN_W]  = entry[2*MIN_W-1 -: MIN_W];
      stat_rd[RX_LSB +: MIN_W]  = entry[MIN_W-1:0];
    end
  end

  AST_IDX_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (idx_q == $past(wdata[IDX_LSB +: PTR_W]))); // R4
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (ctrl_rd[1] == 1'b0 && ctrl_rd[REG_W-1:CTL_W] == '0)); // R10
endmodule

// File: rtl/link_trace_buf.sv
module link_trace_buf #(
  parameter int DEPTH = 32,
  parameter int MAJ_W = 4,
  parameter int MIN_W = 3,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAJ_W-1:0] ls_major,
  input  logic [MIN_W-1:0] ls_tx_minor,
  input  logic [MIN_W-1:0] ls_rx_minor,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] ctrl_rdata,
  output logic [REG_W-1:0] stat_rdata
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int ENT_W = MAJ_W + 2*MIN_W;

  logic             rst_meta_q, rst_sync_q;
  logic             cap_en, clear, trig_en, we, full;
  logic [ENT_W-1:0] trig_val, cur_val, wdata, entry;
  logic [PTR_W-1:0] waddr, wptr, rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign cur_val = {ls_major, ls_tx_minor, ls_rx_minor};

  ltb_regs #(.REG_W(REG_W), .DEPTH(DEPTH), .MAJ_W(MAJ_W), .MIN_W(MIN_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .wr_en(reg_wr), .wr_sel(reg_sel), .wdata(reg_wdata),
    .wptr(wptr), .full(full), .entry(entry), .cap_en(cap_en), .clear(clear),
    .trig_en(trig_en), .trig_val(trig_val), .rd_idx(rd_idx),
    .ctrl_rd(ctrl_rdata), .stat_rd(stat_rdata)
  );

  ltb_capture #(.DEPTH(DEPTH), .MAJ_W(MAJ_W), .MIN_W(MIN_W)) u_capture (
    .clk(clk), .rst_n(rst_sync_q), .cap_en(cap_en), .clear(clear), .trig_en(trig_en),
    .trig_val(trig_val), .cur_val(cur_val), .we(we), .waddr(waddr), .wdata(wdata),
    .wptr(wptr), .full(full)
  );

  ltb_ram #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_ram (
    .clk(clk), .rst_n(rst_sync_q), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_idx), .rdata(entry)
  );
endmodule

// File: tb/tb_link_trace_buf.sv
module tb_link_trace_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ls_major = '0;
  logic [2:0]  ls_tx_minor = '0;
  logic [2:0]  ls_rx_minor = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_rdata, stat_rdata;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;
  string phase = "R1";

  int   m_ram [32];
  int   m_wptr = 0;
  bit   m_full = 0, m_have = 0, m_armed = 0;
  int   m_last = 0;
  int   m_idx = 0;
  logic [31:0] m_ctrl = '0;

  always #4 clk = ~clk;

  link_trace_buf dut (
    .clk(clk), .rst_n(rst_n), .ls_major(ls_major), .ls_tx_minor(ls_tx_minor),
    .ls_rx_minor(ls_rx_minor), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    logic [31:0] s;
    bit v;
    int e;
    v = m_full || (m_idx < m_wptr);
    s = 32'(m_full) | (32'(m_wptr) << 1) | (32'(m_idx) << 6) | (32'(v) << 11);
    if (v) begin
      e = m_ram[m_idx];
      s |= (32'((e >> 6) & 15) << 12) | (32'((e >> 3) & 7) << 16) | (32'(e & 7) << 19);
    end
    return s;
  endfunction

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    int  cur;
    bit  match, go;
    if (!rst_n) begin
      m_wptr = 0; m_full = 0; m_have = 0; m_armed = 0; m_last = 0; m_idx = 0; m_ctrl = '0;
      foreach (m_ram[i]) m_ram[i] = 0;
    end else begin
      cur = (int'(ls_major) << 6) | (int'(ls_tx_minor) << 3) | int'(ls_rx_minor);
      match = (ls_major == m_ctrl[7:4]) && (ls_tx_minor == m_ctrl[10:8]) &&
              (ls_rx_minor == m_ctrl[13:11]);
      if (m_ctrl[2]) begin
        m_wptr = 0; m_full = 0; m_have = 0; m_armed = 0;
      end else if (m_ctrl[0]) begin
        go = !m_ctrl[3] || m_armed || match;
        if (m_ctrl[3] && match) m_armed = 1;
        if (go && (!m_have || cur != m_last)) begin
          m_ram[m_wptr] = cur;
          m_last = cur;
          m_have = 1;
          if (m_wptr == 31) m_full = 1;
          m_wptr = (m_wptr + 1) % 32;
        end
      end
      if (reg_wr && !reg_sel) m_ctrl = reg_wdata & 32'h0000_3FFD;
      if (reg_wr && reg_sel)  m_idx = int'(reg_wdata[10:6]);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      check({phase, " status"}, stat_rdata, exp_stat());
      check({phase, " control"}, ctrl_rdata, m_ctrl);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
    reg_wr = 1'b0;
  endtask

  task automatic drive(int maj, int tx, int rx);
    ls_major = 4'(maj); ls_tx_minor = 3'(tx); ls_rx_minor = 3'(rx);
    tick();
  endtask

  task automatic wr_reg(bit sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
  endtask

  task automatic read_entry(string tag, int idx, int maj, int tx, int rx);
    wr_reg(1'b1, 32'(idx) << 6);
    check({tag, " major"}, 32'(stat_rdata[15:12]), 32'(maj));
    check({tag, " tx minor"}, 32'(stat_rdata[18:16]), 32'(tx));
    check({tag, " rx minor"}, 32'(stat_rdata[21:19]), 32'(rx));
    check({tag, " valid"}, 32'(stat_rdata[11]), 32'd1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
    repeat (4) tick();
    cmp_on = 1'b1;

    phase = "R1";
    check("R1 status after reset", stat_rdata, 32'h0);
    check("R1 control after reset", ctrl_rdata, 32'h0);

    phase = "R10";
    wr_reg(1'b0, 32'hFFFF_FFFF);
    check("R10 control readback", ctrl_rdata, 32'h0000_3FFD);
    wr_reg(1'b0, 32'h0);

    phase = "R7";
    drive(0, 1, 1); drive(1, 0, 0); drive(2, 3, 3);
    check("R7 pointer while disabled", 32'(stat_rdata[5:1]), 32'd0);

    phase = "R2";
    wr_reg(1'b0, 32'h1);
    drive(0, 1, 1); drive(0, 1, 1); drive(0, 3, 3); drive(0, 3, 3); drive(0, 3, 3);
    drive(4, 0, 0); drive(4, 5, 0); drive(7, 7, 0);
    check("R2 pointer counts distinct states", 32'(stat_rdata[5:1]), 32'd5);
    phase = "R9";
    read_entry("R9 entry3", 3, 4, 5, 0);
    read_entry("R3 entry4", 4, 7, 7, 0);
    read_entry("R3 entry1", 1, 0, 3, 3);
    phase = "R4";
    wr_reg(1'b1, 32'(9) << 6);
    check("R4 index beyond pointer invalid", stat_rdata[21:11], 11'h0);
    check("R4 index echoed", 32'(stat_rdata[10:6]), 32'd9);

    phase = "R6";
    wr_reg(1'b0, 32'h5);
    drive(1, 1, 1);
    wr_reg(1'b0, 32'h1);
    check("R6 pointer after clear", 32'(stat_rdata[5:0]), 32'd0);
    drive(1, 1, 1);
    check("R6 first state after clear recorded", 32'(stat_rdata[5:1]), 32'd1);

    phase = "R5";
    wr_reg(1'b0, 32'h5);
    wr_reg(1'b0, 32'h1);
    for (int k = 0; k < 40; k++) drive(k % 16, (k / 16) % 8, k % 8);
    check("R5 full flag", 32'(stat_rdata[0]), 32'd1);
    check("R5 wrapped pointer", 32'(stat_rdata[5:1]), 32'd8);
    read_entry("R5 oldest overwritten", 0, 0, 2, 0);
    read_entry("R5 high slot valid", 31, 15, 1, 7);
    drive(3, 3, 3);
    check("R5 full stays set", 32'(stat_rdata[0]), 32'd1);

    phase = "R8";
    wr_reg(1'b0, 32'h5);
    wr_reg(1'b0, 32'h1 | 32'h8 | (32'd7 << 4) | (32'd2 << 8) | (32'd5 << 11));
    drive(4, 0, 0); drive(7, 2, 0); drive(7, 0, 5); drive(6, 2, 5);
    check("R8 no capture before trigger", 32'(stat_rdata[5:0]), 32'd0);
    drive(7, 2, 5);
    check("R8 trigger state captured", 32'(stat_rdata[5:1]), 32'd1);
    drive(7, 2, 5); drive(4, 0, 0);
    check("R8 capture continues", 32'(stat_rdata[5:1]), 32'd2);
    read_entry("R8 first entry is trigger", 0, 7, 2, 5);

    tick();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule